// File: doc/BRIEF.md
# Power-Stage PWM Channel with Dead-Time Pair

This block is one channel of pulse-width modulation for a switching power stage. A free-running period counter runs while `run` is high. It is compared against an active duty value and two dead-time values to produce a complementary pair of gate signals, `pwm_hi` and `pwm_lo`. A third compare against a trigger point emits a single-cycle `adc_trig` pulse. That pulse can start an external conversion or raise an interrupt at a chosen phase of the period.

Software programs the channel through a simple write port (`wr_en`, `wr_addr`, `wr_data`). A duty write is staged and applied either at the next period start or at once, depending on a control bit. The dead-time values and the control word are locked while the channel runs. An optional restart mode lets a current-limit input end the period early. It does so only during the off phase, after the high-side output has fallen. All three outputs are registered: each reflects the counter value of the previous clock cycle.

Top module: `pspwm_gen`

## Requirements
- R1: While `rst_n` is low, `pwm_hi`, `pwm_lo` and `adc_trig` are low. Reset leaves the active duty at 0, both dead times at 0, the control word at 0, the period at parameter `PER_RST` and the trigger point at all-ones.
- R2: With `run` high and period P (select 0), the counter steps 0,1,…,P-1 and then returns to 0. Each output reflects the counter value from one cycle earlier. With the dead-time code set to 2'b10 (control select 5, bits [1:0]), `pwm_hi` is high exactly when that count is below the effective duty (select 1).
- R3: With dead-time code 2'b10, `pwm_lo` is the complement of `pwm_hi` on every running cycle.
- R4: With any other dead-time code (2'b00, 2'b01, 2'b11), `pwm_hi` is high for counts from the rising dead time (select 2) up to, but not including, the effective duty. `pwm_lo` is high for counts at or above the effective duty plus the falling dead time (select 3).
- R5: A dead-time value from 1 to `DT_MIN`-1 acts as `DT_MIN`; zero stays zero.
- R6: Writes to select 2, 3 and 5 are ignored while `run` is high and accepted while it is low.
- R7: With control bit 2 clear, a written duty first takes effect on the count following the next period wrap or early restart. It also takes effect whenever `run` is low.
- R8: With control bit 2 set, a written duty takes effect on the counter value of the next clock cycle.
- R9: Any active duty from 0 to `DUTY_MIN` keeps `pwm_hi` low and `pwm_lo` continuously high, in both update modes.
- R10: `adc_trig` pulses for one cycle after the count equals the trigger point (select 4). This holds for every value below the period, including 0 to 7. A value at or above the period never pulses.
- R11: With control bit 3 set, `cur_lim` high while the count is at or above the effective duty makes the next count 0, starting a new period.
- R12: With control bit 3 set, `cur_lim` is ignored while the count is below the effective duty.
- R13: `pwm_hi` and `pwm_lo` are never high in the same cycle.
- R14: With `run` low, all three outputs go low on the next cycle and the counter returns to 0. Counting resumes from 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Channel enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select: 0 period, 1 duty, 2 rising dead time, 3 falling dead time, 4 trigger point, 5 control |
| wr_data | input | CW | Write data |
| cur_lim | input | 1 | Current-limit comparator input |
| pwm_hi | output | 1 | High-side gate output |
| pwm_lo | output | 1 | Low-side gate output |
| adc_trig | output | 1 | Single-cycle trigger pulse |

## Verification
The dead-time gap property assumes boundary-update mode and a nonzero rising dead time. Immediate duty loads may move the high-side edge mid-period, so the stimulus checks that case only against the reference model. The locking and current-limit properties assume the control word is changed only while stopped, which the hardware enforces. The stimulus therefore also attempts such writes while running and checks that they are ignored. The current-limit properties assume the period exceeds the count being examined, so the bench keeps the period fixed while it drives `cur_lim`.

// File: rtl/pspwm_pkg.sv
`timescale 1ns/1ps
package pspwm_pkg;

   typedef enum logic [2:0] {
      SEL_PERIOD  = 3'd0,
      SEL_DUTY    = 3'd1,
      SEL_DT_RISE = 3'd2,
      SEL_DT_FALL = 3'd3,
      SEL_TRIG    = 3'd4,
      SEL_CTRL    = 3'd5
   } reg_sel_e;

   typedef struct packed {
      logic       lim_restart;
      logic       imm_load;
      logic [1:0] dt_code;
   } ctrl_t;

   localparam int         CTRL_W         = $bits(ctrl_t);
   localparam logic [1:0] DT_CODE_BYPASS = 2'b10;

endpackage

// File: rtl/pspwm_regs.sv
`timescale 1ns/1ps
module pspwm_regs
   import pspwm_pkg::*;
#(
   parameter int CW      = 16,
   parameter int PER_RST = 100
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          wr_en,
   input  logic [2:0]    wr_addr,
   input  logic [CW-1:0] wr_data,
   input  logic          cycle_end,
   output logic [CW-1:0] period_o,
   output logic [CW-1:0] duty_o,
   output logic [CW-1:0] dtr_o,
   output logic [CW-1:0] dtf_o,
   output logic [CW-1:0] trig_o,
   output ctrl_t         ctrl_o
);

   localparam logic [CW-1:0] PER_RST_V = CW'(PER_RST);

   reg_sel_e      sel;
   logic          hit_per, hit_duty, hit_dtr, hit_dtf, hit_trig, hit_ctrl;
   logic          cfg_open;
   logic [CW-1:0] duty_stage;
   logic [CW-1:0] duty_stage_nxt;

   assign sel      = reg_sel_e'(wr_addr);
   assign hit_per  = wr_en && (sel == SEL_PERIOD);
   assign hit_duty = wr_en && (sel == SEL_DUTY);
   assign hit_dtr  = wr_en && (sel == SEL_DT_RISE);
   assign hit_dtf  = wr_en && (sel == SEL_DT_FALL);
   assign hit_trig = wr_en && (sel == SEL_TRIG);
   assign hit_ctrl = wr_en && (sel == SEL_CTRL);

   // dead times and control are frozen while the stage switches
   assign cfg_open = !run;

   assign duty_stage_nxt = hit_duty ? wr_data : duty_stage;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period_o   <= PER_RST_V;
         trig_o     <= '1;
         duty_stage <= '0;
      end else begin
         if (hit_per)  period_o   <= wr_data;
         if (hit_trig) trig_o     <= wr_data;
         if (hit_duty) duty_stage <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dtr_o  <= '0;
         dtf_o  <= '0;
         ctrl_o <= '0;
      end else if (cfg_open) begin
         if (hit_dtr)  dtr_o  <= wr_data;
         if (hit_dtf)  dtf_o  <= wr_data;
         if (hit_ctrl) ctrl_o <= ctrl_t'(wr_data[CTRL_W-1:0]);
      end
   end

   // active duty: period-boundary transfer or immediate load
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         duty_o <= '0;
      end else if (!run || cycle_end) begin
         duty_o <= duty_stage_nxt;
      end else if (hit_duty && ctrl_o.imm_load) begin
         duty_o <= wr_data;
      end
   end

endmodule

// File: rtl/pspwm_timebase.sv
`timescale 1ns/1ps
module pspwm_timebase #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          cur_lim,
   input  logic          lim_restart,
   input  logic [CW-1:0] period,
   input  logic [CW-1:0] duty_eff,
   output logic [CW-1:0] cnt,
   output logic          cycle_end
);

   logic [CW:0] cnt_inc;
   logic        wrap;
   logic        off_phase;
   logic        lim_hit;

   assign cnt_inc   = {1'b0, cnt} + (CW+1)'(1);
   assign wrap      = cnt_inc >= {1'b0, period};
   assign off_phase = cnt >= duty_eff;
   assign lim_hit   = lim_restart && cur_lim && off_phase;
   assign cycle_end = run && (wrap || lim_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (!run || cycle_end) cnt <= '0;
      else                        cnt <= cnt_inc[CW-1:0];
   end

endmodule

// File: rtl/pspwm_shape.sv
`timescale 1ns/1ps
module pspwm_shape
   import pspwm_pkg::*;
#(
   parameter int CW       = 16,
   parameter int DT_MIN   = 16,
   parameter int DUTY_MIN = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [CW-1:0] cnt,
   input  logic [CW-1:0] duty,
   input  logic [CW-1:0] dtr,
   input  logic [CW-1:0] dtf,
   input  logic [1:0]    dt_code,
   output logic [CW-1:0] duty_eff,
   output logic [CW-1:0] dtr_eff,
   output logic [CW-1:0] dtf_eff,
   output logic          hi_q,
   output logic          lo_q
);

   localparam int            N_DT       = 2;
   localparam logic [CW-1:0] DT_MIN_V   = CW'(DT_MIN);
   localparam logic [CW-1:0] DUTY_MIN_V = CW'(DUTY_MIN);

   logic                   dt_active;
   logic [N_DT-1:0][CW-1:0] dt_raw;
   logic [N_DT-1:0][CW-1:0] dt_eff;
   logic [CW:0]            lo_start;
   logic                   hi_n, lo_n;

   assign dt_active = (dt_code != DT_CODE_BYPASS);
   assign dt_raw[0] = dtr;
   assign dt_raw[1] = dtf;

   // each edge gets its own floor so short nonzero gaps never starve a side
   for (genvar g = 0; g < N_DT; g++) begin : g_dt
      assign dt_eff[g] = (!dt_active || dt_raw[g] == '0) ? '0 :
                         (dt_raw[g] < DT_MIN_V)          ? DT_MIN_V :
                                                           dt_raw[g];
   end

   assign dtr_eff  = dt_eff[0];
   assign dtf_eff  = dt_eff[1];
   assign duty_eff = (duty <= DUTY_MIN_V) ? '0 : duty;
   assign lo_start = {1'b0, duty_eff} + {1'b0, dtf_eff};

   assign hi_n = run && (cnt >= dtr_eff) && (cnt < duty_eff);
   assign lo_n = run && ((duty_eff == '0) || ({1'b0, cnt} >= lo_start));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q <= 1'b0;
         lo_q <= 1'b0;
      end else begin
         hi_q <= hi_n;
         lo_q <= lo_n;
      end
   end

endmodule

// File: rtl/pspwm_trig.sv
`timescale 1ns/1ps
module pspwm_trig #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [CW-1:0] cnt,
   input  logic [CW-1:0] cmp,
   output logic          trig_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) trig_q <= 1'b0;
      else        trig_q <= run && (cnt == cmp);
   end

endmodule

// File: rtl/pspwm_gen.sv
`timescale 1ns/1ps
module pspwm_gen
   import pspwm_pkg::*;
#(
   parameter int CW       = 16,
   parameter int PER_RST  = 100,
   parameter int DT_MIN   = 16,
   parameter int DUTY_MIN = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          wr_en,
   input  logic [2:0]    wr_addr,
   input  logic [CW-1:0] wr_data,
   input  logic          cur_lim,
   output logic          pwm_hi,
   output logic          pwm_lo,
   output logic          adc_trig
);

   if (CW < CTRL_W || CW > 32) begin : g_bad_cw
      $error("pspwm_gen: CW out of range");
   end
   if (DT_MIN < 1 || DT_MIN >= (1 << CW)) begin : g_bad_dt
      $error("pspwm_gen: DT_MIN out of range");
   end
   if (DUTY_MIN < 0 || DUTY_MIN >= (1 << CW)) begin : g_bad_duty
      $error("pspwm_gen: DUTY_MIN out of range");
   end

   logic [CW-1:0] per_w, duty_w, dtr_w, dtf_w, trig_w;
   logic [CW-1:0] cnt_w, duty_eff_w, dtr_eff_w, dtf_eff_w;
   ctrl_t         ctrl_w;
   logic          cycle_end_w;

   pspwm_regs #(.CW(CW), .PER_RST(PER_RST)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .cycle_end(cycle_end_w),
      .period_o (per_w),
      .duty_o   (duty_w),
      .dtr_o    (dtr_w),
      .dtf_o    (dtf_w),
      .trig_o   (trig_w),
      .ctrl_o   (ctrl_w)
   );

   pspwm_timebase #(.CW(CW)) u_tb (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run),
      .cur_lim    (cur_lim),
      .lim_restart(ctrl_w.lim_restart),
      .period     (per_w),
      .duty_eff   (duty_eff_w),
      .cnt        (cnt_w),
      .cycle_end  (cycle_end_w)
   );

   pspwm_shape #(.CW(CW), .DT_MIN(DT_MIN), .DUTY_MIN(DUTY_MIN)) u_shape (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .cnt     (cnt_w),
      .duty    (duty_w),
      .dtr     (dtr_w),
      .dtf     (dtf_w),
      .dt_code (ctrl_w.dt_code),
      .duty_eff(duty_eff_w),
      .dtr_eff (dtr_eff_w),
      .dtf_eff (dtf_eff_w),
      .hi_q    (pwm_hi),
      .lo_q    (pwm_lo)
   );

   pspwm_trig #(.CW(CW)) u_trig (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .cnt   (cnt_w),
      .cmp   (trig_w),
      .trig_q(adc_trig)
   );

endmodule

// File: rtl/pspwm_gen_chk.sv
`timescale 1ns/1ps
module pspwm_gen_chk
   import pspwm_pkg::*;
#(
   parameter int CW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          run,
   input logic          cur_lim,
   input logic          pwm_hi,
   input logic          pwm_lo,
   input logic          adc_trig,
   input logic [CW-1:0] cnt_w,
   input logic [CW-1:0] per_w,
   input logic [CW-1:0] duty_eff_w,
   input logic [CW-1:0] dtr_w,
   input logic [CW-1:0] dtf_w,
   input logic [CW-1:0] dtr_eff_w,
   input ctrl_t         ctrl_w
);

   // R13
   pair_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(pwm_hi && pwm_lo));

   // R14
   stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (!pwm_hi && !pwm_lo && !adc_trig));

   // R6
   cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> ($stable(dtr_w) && $stable(dtf_w) && $stable(ctrl_w)));

   // R11
   lim_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && ctrl_w.lim_restart && cur_lim && cnt_w >= duty_eff_w) |=> (cnt_w == '0));

   // R12
   lim_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && ctrl_w.lim_restart && cur_lim && cnt_w < duty_eff_w &&
       ({1'b0, cnt_w} + (CW+1)'(1)) < {1'b0, per_w})
      |=> (cnt_w == $past(cnt_w) + CW'(1)));

   // R4
   rise_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_w.imm_load && dtr_eff_w != '0 && $rose(pwm_hi)) |-> $past(!pwm_lo));

   // R10
   trig_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adc_trig |-> $past(run));

endmodule

bind pspwm_gen pspwm_gen_chk #(.CW(CW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .run       (run),
   .cur_lim   (cur_lim),
   .pwm_hi    (pwm_hi),
   .pwm_lo    (pwm_lo),
   .adc_trig  (adc_trig),
   .cnt_w     (cnt_w),
   .per_w     (per_w),
   .duty_eff_w(duty_eff_w),
   .dtr_w     (dtr_w),
   .dtf_w     (dtf_w),
   .dtr_eff_w (dtr_eff_w),
   .ctrl_w    (ctrl_w)
);

// File: tb/pspwm_gen_tb.sv
`timescale 1ns/1ps
module pspwm_gen_tb;

   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          run = 1'b0;
   logic          wr_en = 1'b0;
   logic [2:0]    wr_addr = '0;
   logic [CW-1:0] wr_data = '0;
   logic          cur_lim = 1'b0;
   logic          pwm_hi, pwm_lo, adc_trig;

   int    n_vec = 0;
   int    n_bad = 0;
   string phase = "R1";
   bit    done = 1'b0;

   always #10 clk = ~clk;

   pspwm_gen #(.CW(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .run(run), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .cur_lim(cur_lim), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo),
      .adc_trig(adc_trig)
   );

   // behavioural reference of the channel, stepped on each rising edge
   int m_per, m_duty, m_stage, m_dtr, m_dtf, m_trig, m_ctrl, m_cnt;
   bit m_hi, m_lo, m_tr;
   int de, er, ef, nstage, nxt_duty;
   bit on_dt, hit, wrapped, nh, nl, nt;

   function automatic int floor_dt(int v, bit act);
      if (!act || v == 0) return 0;
      return (v < 16) ? 16 : v;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_per = 100; m_duty = 0; m_stage = 0; m_dtr = 0; m_dtf = 0;
         m_trig = 65535; m_ctrl = 0; m_cnt = 0;
         m_hi = 0; m_lo = 0; m_tr = 0;
      end else begin
         de    = (m_duty <= 16) ? 0 : m_duty;
         on_dt = (m_ctrl % 4) != 2;
         er    = floor_dt(m_dtr, on_dt);
         ef    = floor_dt(m_dtf, on_dt);
         nh    = run && m_cnt >= er && m_cnt < de;
         nl    = run && (de == 0 || m_cnt >= de + ef);
         nt    = run && m_cnt == m_trig;
         hit   = ((m_ctrl / 8) % 2 == 1) && cur_lim && m_cnt >= de;
         wrapped = run && (m_cnt + 1 >= m_per || hit);
         nstage = (wr_en && wr_addr == 3'd1) ? int'(wr_data) : m_stage;
         nxt_duty = m_duty;
         if (!run || wrapped) nxt_duty = nstage;
         else if (wr_en && wr_addr == 3'd1 && (m_ctrl / 4) % 2 == 1) nxt_duty = int'(wr_data);
         if (wr_en) begin
            case (wr_addr)
               3'd0: m_per  = int'(wr_data);
               3'd4: m_trig = int'(wr_data);
               3'd2: if (!run) m_dtr  = int'(wr_data);
               3'd3: if (!run) m_dtf  = int'(wr_data);
               3'd5: if (!run) m_ctrl = int'(wr_data) % 16;
               default: ;
            endcase
         end
         m_stage = nstage;
         m_duty  = nxt_duty;
         m_cnt   = (!run || wrapped) ? 0 : m_cnt + 1;
         m_hi = nh; m_lo = nl; m_tr = nt;
      end
      #5;
      if (rst_n && !done) begin
         n_vec++;
         if (pwm_hi !== m_hi || pwm_lo !== m_lo || adc_trig !== m_tr) begin
            n_bad++;
            $display("FAIL %s: hi/lo/trig actual %b%b%b expected %b%b%b at %0t",
                     phase, pwm_hi, pwm_lo, adc_trig, m_hi, m_lo, m_tr, $time);
         end
         if (pwm_hi && pwm_lo) begin
            n_bad++;
            $display("FAIL R13: hi/lo actual 11 expected not both high at %0t", $time);
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input int d);
      wr_en = 1'b1; wr_addr = a; wr_data = CW'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   initial begin
      tick(3);
      // R1: reset state
      n_vec++;
      if (pwm_hi !== 1'b0 || pwm_lo !== 1'b0 || adc_trig !== 1'b0) begin
         n_bad++;
         $display("FAIL R1: hi/lo/trig actual %b%b%b expected 000", pwm_hi, pwm_lo, adc_trig);
      end
      rst_n = 1'b1;
      tick(2);

      phase = "R2"; wr(3'd0, 40); wr(3'd5, 2); wr(3'd1, 20); run = 1; tick(85);
      phase = "R3"; tick(45);
      phase = "R14"; run = 0; tick(4);
      phase = "R5"; wr(3'd5, 0); wr(3'd2, 5); wr(3'd3, 3); wr(3'd1, 30); run = 1; tick(90);
      phase = "R4"; run = 0; wr(3'd2, 20); wr(3'd3, 24); wr(3'd1, 24); wr(3'd5, 3); run = 1; tick(90);
      phase = "R6"; wr(3'd2, 2); wr(3'd3, 0); wr(3'd5, 2); tick(90);
      phase = "R7"; tick(7); wr(3'd1, 33); tick(20); wr(3'd1, 22); tick(70);
      phase = "R8"; run = 0; wr(3'd5, 4); run = 1; tick(25); wr(3'd1, 35); tick(10); wr(3'd1, 18); tick(60);
      phase = "R9"; wr(3'd1, 16); tick(45); wr(3'd1, 10); tick(45); wr(3'd1, 0); tick(20);
      run = 0; wr(3'd5, 0); run = 1; wr(3'd1, 16); tick(45); wr(3'd1, 17); tick(45);
      phase = "R10"; wr(3'd1, 25); wr(3'd4, 3); tick(85); wr(3'd4, 0); tick(85);
      wr(3'd4, 39); tick(85); wr(3'd4, 60); tick(85);
      phase = "R12"; run = 0; wr(3'd5, 8); wr(3'd1, 30); wr(3'd4, 5); run = 1; tick(4);
      cur_lim = 1; tick(10); cur_lim = 0; tick(40);
      phase = "R11"; tick(5); cur_lim = 1; tick(12); cur_lim = 0; tick(20);
      cur_lim = 1; tick(3); cur_lim = 0; tick(50);
      phase = "R13"; run = 0; wr(3'd5, 5); wr(3'd2, 16); wr(3'd3, 17); run = 1;
      for (int i = 0; i < 30; i++) begin
         wr(3'd1, (i * 7) % 45);
         tick(8);
      end
      phase = "R14"; tick(13); run = 0; tick(3); run = 1; tick(50);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #1_000_000;
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual running expected finished");
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule